// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Sequencer

This block is one DMA channel that runs a small command program held in memory. Each command is a 16-byte descriptor. The channel fetches a descriptor from the address in its command pointer, decodes the opcode and acts on it. It can move bytes from memory to an output byte stream, move bytes from an input byte stream into memory, store or load a single word, do nothing, or stop. When the action is done it writes the residual count and its own status back into the descriptor. Each descriptor also carries a wait, an interrupt and a branch condition. The channel checks these against the device-status byte before it moves on to the next command.

Software drives the channel through a small register port. Writes to the control register use the upper half of the word as a per-bit mask and the lower half as the new bit values, so that single status bits change without a read-modify-write. A run starts when software sets the run bit, or when it sets the wake bit after a stop command. Software stops the channel by clearing the run bit and then polling until the active bit reads 0. A memory response with an error flag parks the channel in a dead state.

Top module: `cmdlist_dma`

## Requirements
- R1: After reset every register reads 0. The register map is: reg_addr 0 is control on write and status on read, 1 is the command pointer (its low 4 bits are forced to 0), 2 is interrupt select, 3 is branch select and 4 is wait select. A control write changes status bit i (i in 15:0, bit 9 excluded) only when reg_wdata[16+i] is 1. The active (bit 10) and dead (bit 11) bits can only be cleared this way, never set.
- R2: A control write that raises run (bit 15), or that sets wake (bit 12) while run is 1, sets active when dead is 0. The channel then reads the 4 descriptor words at the command pointer. Word 0 holds the requested count in bits 15:0 and the command in 31:16. Word 1 holds the data address, word 2 the extra field, and word 3 the residual in 15:0 and the status in 31:16. The opcode is command bits 14:12. Wake is cleared when the fetch begins.
- R3: Opcodes 0 and 1 read the requested number of bytes from memory in rising address order and present them on the output stream, one byte per handshake. so_last is 1 only with the final byte of opcode 1.
- R4: Opcodes 2 and 3 write each input-stream byte to the next address, using a single-lane byte enable. Opcode 3 also ends on a byte that carries si_last. Opcode 2 ignores si_last.
- R5: Opcode 4 writes the extra field to the word at the data address. Opcode 5 reads the word at the data address into descriptor word 2.
- R6: When a descriptor other than stop completes, word 3 is written as {status[15:0], requested minus transferred}.
- R7: A condition is true when (status[7:0] AND select[23:16]) equals select[7:0]. Command bits 5:4 (interrupt), 3:2 (branch) and 1:0 (wait) each mean 0 never, 1 if the condition is true, 2 if it is false, 3 always.
- R8: When the branch fires, the command pointer loads the extra field (aligned to 16) and branch-taken (bit 8) becomes 1. Otherwise the pointer advances by 16 and bit 8 becomes 0.
- R9: When the interrupt fires, irq is high for exactly one cycle as the channel advances.
- R10: While the wait fires, the channel holds after the write-back and does not advance the pointer.
- R11: Opcode 7 clears active with no write-back and leaves the pointer unchanged. Only a wake or run write restarts the channel, and it then fetches at the same pointer.
- R12: When run is cleared, the channel gives up the current descriptor at its next non-memory step, clears active and writes nothing back.
- R13: While pause (bit 14) is 1, the channel issues no new fetch.
- R14: A memory response with mem_err sets dead, clears active and stops all memory requests until dead is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_be | output | 4 | Byte enables for writes |
| mem_addr | output | AW | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory response |
| mem_err | input | 1 | Error flag with the response |
| so_valid | output | 1 | Output stream byte valid |
| so_data | output | 8 | Output stream byte |
| so_last | output | 1 | End marker on the output stream |
| so_ready | input | 1 | Output stream accepts the byte |
| si_valid | input | 1 | Input stream byte valid |
| si_data | input | 8 | Input stream byte |
| si_last | input | 1 | End marker on the input stream |
| si_ready | output | 1 | Channel accepts an input byte |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench builds the channel with AW = 16 against a 256-byte memory model. Any address at or above 0x100 returns an error response, so the dead path can be reached with an ordinary descriptor and no special hook. The small address width keeps descriptor chains, branch targets and byte lanes easy to compute. Stalls on the output stream, early end markers on input, and wait and pause stalls are each tested in their own scenario.

// File: rtl/cmdlist_dma.sv
module cmdlist_dma #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [3:0]    mem_be,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          so_valid,
  output logic [7:0]    so_data,
  output logic          so_last,
  input  logic          so_ready,
  input  logic          si_valid,
  input  logic [7:0]    si_data,
  input  logic          si_last,
  output logic          si_ready,
  output logic          irq
);
  localparam int B_RUN = 15, B_PAU = 14, B_WAKE = 12, B_DEAD = 11, B_ACT = 10, B_BT = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_F0, S_F1, S_F2, S_EXEC, S_ORD, S_OTX, S_IRX, S_IWR,
    S_STW, S_LDR, S_LDW, S_WB, S_ADV
  } state_t;

  state_t        state;
  logic [15:0]   st;
  logic [AW-1:0] cptr, daddr;
  logic [15:0]   isel, bsel, wsel;
  logic [15:0]   cnt_req, xcnt;
  logic [2:0]    op;
  logic [5:0]    ctl;
  logic [31:0]   dep, ld_q;
  logic [7:0]    byte_q;
  logic          last_q;

  function automatic logic hit(input logic [15:0] sel, input logic [7:0] dev);
    return (dev & sel[15:8]) == sel[7:0];
  endfunction

  function automatic logic fire(input logic [1:0] f, input logic c);
    return (f == 2'd3) || (f == 2'd1 && c) || (f == 2'd2 && !c);
  endfunction

  wire        wait_on = fire(ctl[1:0], hit(wsel, st[7:0]));
  wire        br_on   = fire(ctl[3:2], hit(bsel, st[7:0]));
  wire        int_on  = fire(ctl[5:4], hit(isel, st[7:0]));
  wire        halt    = !st[B_RUN] || !st[B_ACT];
  wire [15:0] xnext   = xcnt + 16'd1;
  wire [15:0] resid   = cnt_req - xcnt;

  wire        wr_ctl  = reg_wr && reg_addr == 3'd0;
  wire [15:0] wm      = reg_wdata[31:16];
  wire [15:0] wv      = reg_wdata[15:0];
  wire        run_nx  = wm[B_RUN] ? wv[B_RUN] : st[B_RUN];
  wire        dead_nx = st[B_DEAD] && !(wm[B_DEAD] && !wv[B_DEAD]);
  wire        start_req = wr_ctl && run_nx && !dead_nx &&
                          ((wm[B_RUN] && wv[B_RUN] && !st[B_RUN]) || (wm[B_WAKE] && wv[B_WAKE]));

  wire [AW-1:0] dword = {daddr[AW-1:2], 2'b00};

  assign mem_req = state inside {S_F0, S_F1, S_F2, S_ORD, S_IWR, S_STW, S_LDR, S_LDW, S_WB};
  assign mem_we  = state inside {S_IWR, S_STW, S_LDW, S_WB};
  assign mem_be  = (state == S_IWR) ? (4'b0001 << daddr[1:0]) : 4'hF;
  assign so_valid = state == S_OTX;
  assign so_data  = byte_q;
  assign so_last  = (op == 3'd1) && (xnext == cnt_req);
  assign si_ready = state == S_IRX;

  always_comb begin
    case (state)
      S_F0:                  mem_addr = cptr;
      S_F1:                  mem_addr = cptr + AW'(4);
      S_F2, S_LDW:           mem_addr = cptr + AW'(8);
      S_WB:                  mem_addr = cptr + AW'(12);
      S_ORD, S_IWR, S_STW, S_LDR: mem_addr = dword;
      default:               mem_addr = '0;
    endcase
    case (state)
      S_IWR:   mem_wdata = {4{byte_q}};
      S_STW:   mem_wdata = dep;
      S_LDW:   mem_wdata = ld_q;
      S_WB:    mem_wdata = {st, resid};
      default: mem_wdata = '0;
    endcase
    case (reg_addr)
      3'd0:    reg_rdata = {16'h0, st};
      3'd1:    reg_rdata = 32'(cptr);
      3'd2:    reg_rdata = {8'h0, isel[15:8], 8'h0, isel[7:0]};
      3'd3:    reg_rdata = {8'h0, bsel[15:8], 8'h0, bsel[7:0]};
      3'd4:    reg_rdata = {8'h0, wsel[15:8], 8'h0, wsel[7:0]};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; st <= '0; cptr <= '0; daddr <= '0;
      isel <= '0; bsel <= '0; wsel <= '0; cnt_req <= '0; xcnt <= '0;
      op <= '0; ctl <= '0; dep <= '0; ld_q <= '0; byte_q <= '0; last_q <= 1'b0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (mem_req && mem_ack && mem_err) begin
        st[B_DEAD] <= 1'b1;
        st[B_ACT]  <= 1'b0;
        state      <= S_IDLE;
      end else begin
        case (state)
          S_IDLE:
            if (!st[B_RUN]) st[B_ACT] <= 1'b0;
            else if (st[B_ACT] && !st[B_PAU] && !st[B_DEAD]) begin
              st[B_WAKE] <= 1'b0;
              state <= S_F0;
            end
          S_F0: if (mem_ack) begin
            cnt_req <= mem_rdata[15:0];
            op  <= mem_rdata[30:28];
            ctl <= mem_rdata[21:16];
            state <= S_F1;
          end
          S_F1: if (mem_ack) begin daddr <= mem_rdata[AW-1:0]; state <= S_F2; end
          S_F2: if (mem_ack) begin dep <= mem_rdata; xcnt <= '0; state <= S_EXEC; end
          S_EXEC:
            if (halt) begin st[B_ACT] <= 1'b0; state <= S_IDLE; end
            else case (op)
              3'd0, 3'd1: state <= (cnt_req == 16'd0) ? S_WB : S_ORD;
              3'd2, 3'd3: state <= (cnt_req == 16'd0) ? S_WB : S_IRX;
              3'd4:       state <= S_STW;
              3'd5:       state <= S_LDR;
              3'd6:       state <= S_WB;
              default: begin st[B_ACT] <= 1'b0; state <= S_IDLE; end
            endcase
          S_ORD: if (mem_ack) begin
            byte_q <= 8'(mem_rdata >> {daddr[1:0], 3'b000});
            state <= S_OTX;
          end
          S_OTX:
            if (halt) begin st[B_ACT] <= 1'b0; state <= S_IDLE; end
            else if (so_ready) begin
              xcnt  <= xnext;
              daddr <= daddr + AW'(1);
              state <= (xnext == cnt_req) ? S_WB : S_ORD;
            end
          S_IRX:
            if (halt) begin st[B_ACT] <= 1'b0; state <= S_IDLE; end
            else if (si_valid) begin byte_q <= si_data; last_q <= si_last; state <= S_IWR; end
          S_IWR: if (mem_ack) begin
            xcnt  <= xnext;
            daddr <= daddr + AW'(1);
            state <= ((op == 3'd3 && last_q) || xnext == cnt_req) ? S_WB : S_IRX;
          end
          S_STW: if (mem_ack) state <= S_WB;
          S_LDR: if (mem_ack) begin ld_q <= mem_rdata; state <= S_LDW; end
          S_LDW: if (mem_ack) state <= S_WB;
          S_WB:  if (mem_ack) state <= S_ADV;
          S_ADV:
            if (halt) begin st[B_ACT] <= 1'b0; state <= S_IDLE; end
            else if (!st[B_PAU] && !wait_on) begin
              irq <= int_on;
              st[B_BT] <= br_on;
              cptr <= br_on ? {dep[AW-1:4], 4'b0000} : cptr + AW'(16);
              state <= S_F0;
            end
          default: state <= S_IDLE;
        endcase
      end
      if (wr_ctl) begin
        for (int i = 0; i < 16; i++)
          if (wm[i] && i != 9 && !((i == B_ACT || i == B_DEAD) && wv[i])) st[i] <= wv[i];
        if (start_req) st[B_ACT] <= 1'b1;
      end
      if (reg_wr && reg_addr == 3'd1) cptr <= {reg_wdata[AW-1:4], 4'b0000};
      if (reg_wr && reg_addr == 3'd2) isel <= {reg_wdata[23:16], reg_wdata[7:0]};
      if (reg_wr && reg_addr == 3'd3) bsel <= {reg_wdata[23:16], reg_wdata[7:0]};
      if (reg_wr && reg_addr == 3'd4) wsel <= {reg_wdata[23:16], reg_wdata[7:0]};
    end
  end

  p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  p_so_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    so_valid && !so_ready && st[B_RUN] && st[B_ACT] |=> so_valid && $stable(so_data));
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_pause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    st[B_PAU] && state == S_IDLE |=> !mem_req);
  p_dead_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
    st[B_DEAD] |-> !mem_req);
  p_err_dead_r14: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err && !reg_wr |=> st[B_DEAD] && !st[B_ACT]);
endmodule

// File: tb/test_cmdlist_dma.sv
module test_cmdlist_dma;
  localparam int AW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
  logic [3:0] mem_be;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic so_valid, so_last, so_ready;
  logic [7:0] so_data;
  logic si_valid, si_last, si_ready;
  logic [7:0] si_data;
  logic irq;

  always #5 clk = ~clk;

  cmdlist_dma #(.AW(AW)) i_cmdlist_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .so_valid(so_valid), .so_data(so_data), .so_last(so_last),
    .so_ready(so_ready), .si_valid(si_valid), .si_data(si_data), .si_last(si_last),
    .si_ready(si_ready), .irq(irq));

  int tests = 0, fails = 0;
  logic [31:0] mem [64];
  logic [7:0] ob [256];
  logic ol [256];
  int on = 0;
  logic [7:0] src_b [256];
  logic src_l [256];
  int sidx = 0, slen = 0;
  int irq_cnt = 0;
  logic rdy_tog = 1'b0;
  logic [31:0] cyc = '0;

  assign so_ready = rdy_tog ? cyc[0] : 1'b1;
  assign si_valid = sidx < slen;
  assign si_data  = src_b[sidx[7:0]];
  assign si_last  = src_l[sidx[7:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (irq) irq_cnt <= irq_cnt + 1;
    if (so_valid && so_ready) begin ob[on[7:0]] <= so_data; ol[on[7:0]] <= so_last; on <= on + 1; end
    if (si_valid && si_ready) sidx <= sidx + 1;
  end

  task automatic mem_model();
    forever begin
      @(posedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        mem_err <= mem_addr[AW-1:8] != '0;
        if (mem_addr[AW-1:8] == '0) begin
          mem_rdata <= mem[mem_addr[7:2]];
          if (mem_we)
            for (int b = 0; b < 4; b++)
              if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] = mem_wdata[8*b +: 8];
        end
      end else begin
        mem_ack <= 1'b0;
        mem_err <= 1'b0;
      end
    end
  endtask

  function automatic logic [15:0] mk(input int o, input int i, input int b, input int w);
    return 16'((o << 12) | (i << 4) | (b << 2) | w);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 3'd0;
  endtask

  task automatic wait_inactive(input string req);
    logic [31:0] s;
    bit done = 0;
    for (int k = 0; k < 3000 && !done; k++) begin
      rd(3'd0, s);
      if (!s[10]) done = 1;
    end
    chk(req, 32'(done), 32'd1);
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst_n = 1'b0; rdy_tog = 1'b0;
    for (int k = 0; k < 64; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start(input logic [31:0] ptr);
    wr(3'd1, ptr);
    wr(3'd0, 32'h8000_8000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    hard_reset();
    rd(3'd0, d); chk("R1 status after reset", d, 0);
    rd(3'd1, d); chk("R1 cmdptr after reset", d, 0);
    chk("R1 no request after reset", {29'd0, mem_req, irq, so_valid}, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    hard_reset();
    wr(3'd0, 32'h00FF_005A); rd(3'd0, d); chk("R1 masked dev write", d, 32'h005A);
    wr(3'd0, 32'h000F_FFFF); rd(3'd0, d); chk("R1 partial mask", d, 32'h005F);
    wr(3'd0, 32'h0C00_0C00); rd(3'd0, d); chk("R1 dead/active not settable", d, 32'h005F);
    wr(3'd1, 32'h1237); rd(3'd1, d); chk("R1 cmdptr aligned", d, 32'h1230);
    wr(3'd4, 32'hAB12_CD34); rd(3'd4, d); chk("R7 select fields", d, 32'h0012_0034);
  endtask

  task automatic t_out();
    logic [31:0] d;
    int n0 = on, i0 = irq_cnt;
    hard_reset();
    rdy_tog = 1'b1;
    mem[32] = 32'h4433_2211; mem[33] = 32'h0000_6655;
    mem[0] = {mk(1, 3, 0, 0), 16'd3}; mem[1] = 32'h81;
    mem[4] = {mk(0, 0, 0, 0), 16'd2}; mem[5] = 32'h84;
    mem[8] = {mk(7, 0, 0, 0), 16'd0};
    start(0);
    wait_inactive("R3 output program ends");
    chk("R3 byte count", 32'(on - n0), 5);
    chk("R3 byte0", ob[n0[7:0]], 32'h22);
    chk("R3 byte2", ob[8'(n0 + 2)], 32'h44);
    chk("R3 byte3", ob[8'(n0 + 3)], 32'h55);
    chk("R3 byte4", ob[8'(n0 + 4)], 32'h66);
    chk("R3 last flags", {27'd0, ol[n0[7:0]], ol[8'(n0 + 1)], ol[8'(n0 + 2)], ol[8'(n0 + 3)], ol[8'(n0 + 4)]}, 32'b00100);
    chk("R6 writeback D0", mem[3], 32'h8400_0000);
    chk("R6 writeback D1", mem[7], 32'h8400_0000);
    chk("R11 stop no writeback", mem[11], 0);
    chk("R9 one irq", 32'(irq_cnt - i0), 1);
    rd(3'd0, d); chk("R11 status after stop", d, 32'h8000);
    rd(3'd1, d); chk("R11 ptr at stop", d, 32'h20);
    rdy_tog = 1'b0;
  endtask

  task automatic t_in();
    hard_reset();
    mem[36] = 32'h1111_1111;
    mem[0] = {mk(3, 0, 0, 0), 16'd4}; mem[1] = 32'h91;
    mem[4] = {mk(2, 0, 0, 0), 16'd2}; mem[5] = 32'h98;
    mem[8] = {mk(7, 0, 0, 0), 16'd0};
    src_b[8'(slen)] = 8'hA1; src_l[8'(slen)] = 1'b0;
    src_b[8'(slen + 1)] = 8'hA2; src_l[8'(slen + 1)] = 1'b1;
    src_b[8'(slen + 2)] = 8'hB1; src_l[8'(slen + 2)] = 1'b1;
    src_b[8'(slen + 3)] = 8'hB2; src_l[8'(slen + 3)] = 1'b0;
    slen = slen + 4;
    start(0);
    wait_inactive("R4 input program ends");
    chk("R4 bytes with lanes", mem[36], 32'h11A2_A111);
    chk("R6 residual after early end", mem[3], 32'h8400_0002);
    chk("R4 marker ignored by opcode 2", mem[38], 32'h0000_B2B1);
    chk("R6 residual zero", mem[7], 32'h8400_0000);
  endtask

  task automatic t_ls();
    hard_reset();
    mem[0] = {mk(4, 0, 0, 0), 16'd0}; mem[1] = 32'hA0; mem[2] = 32'hCAFE_F00D;
    mem[4] = {mk(5, 0, 0, 0), 16'd0}; mem[5] = 32'hA4;
    mem[41] = 32'h1234_5678;
    mem[8] = {mk(7, 0, 0, 0), 16'd0};
    start(0);
    wait_inactive("R5 load/store program ends");
    chk("R5 store word", mem[40], 32'hCAFE_F00D);
    chk("R5 load word", mem[6], 32'h1234_5678);
    chk("R6 store writeback", mem[3], 32'h8400_0000);
  endtask

  task automatic t_branch();
    logic [31:0] d;
    int i0;
    hard_reset();
    i0 = irq_cnt;
    wr(3'd2, 32'h0001_0001); wr(3'd3, 32'h0001_0001); wr(3'd0, 32'h00FF_0001);
    mem[0]  = {mk(6, 2, 1, 0), 16'd0}; mem[2] = 32'h40;
    mem[16] = {mk(6, 1, 2, 0), 16'd0}; mem[18] = 32'h80;
    mem[20] = {mk(7, 0, 0, 0), 16'd0};
    start(0);
    wait_inactive("R8 branch program ends");
    rd(3'd1, d); chk("R8 taken then not taken", d, 32'h50);
    rd(3'd0, d); chk("R8 BT clear after fallthrough", d, 32'h8001);
    chk("R7 status in writeback D0", mem[3], 32'h8401_0000);
    chk("R8 BT seen in next writeback", mem[19], 32'h8501_0000);
    chk("R9 irq only on true-if-set", 32'(irq_cnt - i0), 1);
    hard_reset();
    mem[0] = {mk(6, 0, 3, 0), 16'd0}; mem[2] = 32'h3F;
    mem[12] = {mk(7, 0, 0, 0), 16'd0};
    start(0);
    wait_inactive("R8 always branch ends");
    rd(3'd1, d); chk("R8 always branch aligned target", d, 32'h30);
    rd(3'd0, d); chk("R8 BT set", d, 32'h8100);
  endtask

  task automatic t_wait_wake();
    logic [31:0] d;
    hard_reset();
    wr(3'd4, 32'h0002_0002); wr(3'd0, 32'h00FF_0002);
    mem[0] = {mk(6, 0, 0, 1), 16'd0};
    mem[4] = {mk(7, 0, 0, 0), 16'd0};
    start(0);
    repeat (30) @(negedge clk);
    rd(3'd1, d); chk("R10 held at pointer", d, 0);
    rd(3'd0, d); chk("R10 still active", d, 32'h8402);
    chk("R10 writeback before wait", mem[3], 32'h8402_0000);
    wr(3'd0, 32'h00FF_0000);
    wait_inactive("R10 released");
    rd(3'd1, d); chk("R10 advanced to stop", d, 32'h10);
    repeat (20) @(negedge clk);
    rd(3'd1, d); chk("R11 stop stays put", d, 32'h10);
    mem[4] = {mk(6, 0, 0, 0), 16'd0};
    mem[8] = {mk(7, 0, 0, 0), 16'd0};
    wr(3'd0, 32'h1000_1000);
    wait_inactive("R11 wake run ends");
    rd(3'd1, d); chk("R11 wake refetched same pointer", d, 32'h20);
    rd(3'd0, d); chk("R2 wake cleared on fetch", d, 32'h8000);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    int reqs = 0;
    hard_reset();
    mem[0] = {mk(2, 0, 0, 0), 16'd4}; mem[1] = 32'h90;
    start(0);
    repeat (20) @(negedge clk);
    rd(3'd0, d); chk("R12 active while blocked", d, 32'h8400);
    wr(3'd0, 32'hA000_0000);
    wait_inactive("R12 active drops");
    rd(3'd0, d); chk("R12 status after stop", d, 0);
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (mem_req) reqs++; end
    chk("R12 no requests after abandon", 32'(reqs), 0);
    chk("R12 no writeback", mem[3], 0);
  endtask

  task automatic t_pause();
    logic [31:0] d;
    int reqs = 0;
    hard_reset();
    mem[0] = {mk(7, 0, 0, 0), 16'd0};
    wr(3'd1, 0);
    wr(3'd0, 32'h4000_4000);
    wr(3'd0, 32'h8000_8000);
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (mem_req) reqs++; end
    chk("R13 no fetch while paused", 32'(reqs), 0);
    rd(3'd0, d); chk("R13 paused status", d, 32'hC400);
    wr(3'd0, 32'h4000_0000);
    wait_inactive("R13 resumes");
    rd(3'd0, d); chk("R13 status after resume", d, 32'h8000);
  endtask

  task automatic t_err();
    logic [31:0] d;
    int reqs = 0;
    hard_reset();
    mem[0] = {mk(0, 0, 0, 0), 16'd1}; mem[1] = 32'h200;
    start(0);
    wait_inactive("R14 error ends run");
    rd(3'd0, d); chk("R14 dead set", d, 32'h8800);
    wr(3'd0, 32'h8000_8000);
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (mem_req) reqs++; end
    chk("R14 no restart while dead", 32'(reqs), 0);
    wr(3'd0, 32'hFC00_0000);
    rd(3'd0, d); chk("R1 reset write clears run", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog all-R actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    fork mem_model(); join_none
    t_reset();
    t_mask();
    t_out();
    t_in();
    t_ls();
    t_branch();
    t_wait_wake();
    t_abort();
    t_pause();
    t_err();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule